// File: doc/BRIEF.md
# Prefixed Opcode Stream Framer

This block sits at the front of an instruction pipeline for an 8-bit processor whose opcode space is extended by prefix bytes. It takes instruction bytes one at a time over a valid/ready byte port and groups them into complete instructions. Each opcode byte is split into its bit fields. A small classifier uses those fields to decide whether a signed displacement, an immediate byte or a two-byte immediate still has to follow.

Once the last byte of an instruction has been taken, the block holds a descriptor until the consumer acknowledges it. The descriptor gives the start address, the byte count with prefixes included, the opcode page and the chosen index register. It also gives the final opcode and its fields, the displacement and the immediate value. While the descriptor is held, the byte port is stalled. After an acknowledge, the next instruction starts at the start address plus the length. A load strobe points the block at a new address and drops any partly collected instruction.

Top module: `insn_framer`

## Requirements
- R1: The descriptor gives the final opcode split into x = bits 7:6, y = bits 5:3, z = bits 2:0, p = bits 5:4 and q = bit 3.
- R2: Byte 0xCB selects the bit page (code 1) and 0xED selects the extended page (code 2). Byte 0xDD selects the indexed page (code 3) with index select 0, and 0xFD does the same with index select 1. On the indexed page a later 0xDD, 0xFD or 0xED replaces the earlier prefix. The main page is code 0, and index select is 0 on every page other than the two indexed ones.
- R3: On the indexed page, 0xCB moves to the indexed-bit page (code 4) and keeps the index select. The next byte is the displacement and the byte after that is the final opcode. The instruction then completes without any further operands.
- R4: On the main page, some forms take a two-byte immediate, sent low byte first: x0/z1/q0, x0/z2 with bit 5 set, x3/z2, x3/z4, x3/z3/y0 and x3/z5/q1/p0. Some forms take one byte, which is zero-extended in the immediate: x0/z0 with y≥2, x0/z6, x3/z6, and x3/z3 with y 2 or 3. Every other main-page opcode completes at once.
- R5: On the extended page, only x1/z3 takes a two-byte immediate. Every other opcode completes with no operand bytes.
- R6: On the indexed page, a displacement byte is taken for 0x34, 0x35 and 0x36, for x2 with z6, and for x1 with z6 or y6, except 0x76. 0x36 also takes one immediate byte after its displacement. With no displacement, the displacement field reads 0.
- R7: The descriptor marks an indexed-page opcode as fall-through (flag 1) when it uses neither a displacement nor an index register or half-register. Its operand bytes are then taken as on the main page. On all non-indexed pages the flag is 0.
- R8: The fetch address steps by one for each accepted byte and wraps modulo 2^16. The length counts every byte taken, prefixes included. After an acknowledge, the next start address is the previous start plus the length.
- R9: The descriptor is valid from the cycle after the last byte is accepted until the cycle after an acknowledge. It stays stable during that time and the byte port is not ready. The done output is high only in the first valid cycle.
- R10: An active-low synchronous reset returns the block to opcode wait at address 0. A load strobe, which takes priority, drops any partial or held instruction and restarts at the load address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Restart at load_addr |
| load_addr | input | 16 | New start address |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be taken |
| desc_ack | input | 1 | Consumer takes the descriptor |
| desc_valid | output | 1 | Descriptor held |
| desc_done | output | 1 | First cycle of a new descriptor |
| desc_start | output | 16 | Address of the first byte |
| desc_len | output | 4 | Bytes taken, prefixes included |
| desc_page | output | 3 | Opcode page code |
| desc_iy | output | 1 | Index register select |
| desc_op | output | 8 | Final opcode byte |
| desc_x | output | 2 | Opcode bits 7:6 |
| desc_y | output | 3 | Opcode bits 5:3 |
| desc_z | output | 3 | Opcode bits 2:0 |
| desc_p | output | 2 | Opcode bits 5:4 |
| desc_q | output | 1 | Opcode bit 3 |
| desc_disp | output | 8 | Signed displacement byte |
| desc_imm | output | 16 | Immediate value |
| desc_fall | output | 1 | Indexed opcode decoded as main page |

## Verification
The bench targets the forms where the operand count depends on a single bit.

- A design that tested x0/z2 without bit 5, or treated x0/z6 on the extended page as it does on the main page, would finish early or stall for an extra byte. The bench checks the length and the done timing at these points.
- The bench covers the indexed-bit ordering, the displacement-then-immediate form 0x36, the 0x76 exception and chained prefixes. A swapped displacement/opcode order or a stale index select would show up as a wrong displacement field, opcode field or index select.
- Address wrap at 0xFFFF, a load in the middle of an instruction and a reset in the middle of an instruction are also driven. A design that got these wrong would report a wrong start address or length.

// File: rtl/insn_framer_pkg.sv
// Shared types for the opcode stream framer.
// Page codes are visible at the descriptor port, so their values are fixed.
package insn_framer_pkg;

    typedef enum logic [2:0] {
        PG_MAIN   = 3'd0,
        PG_BIT    = 3'd1,
        PG_EXT    = 3'd2,
        PG_IDX    = 3'd3,
        PG_IDXBIT = 3'd4
    } page_e;

    typedef enum logic [2:0] {
        ST_OP,
        ST_DISP,
        ST_IMLO,
        ST_IMHI,
        ST_HOLD
    } seq_state_e;

endpackage

// File: rtl/insn_opclass.sv
// Operand classifier: for the current page and one byte, says whether the
// byte is a prefix (and which page follows), whether a displacement follows,
// how many immediate bytes follow, and whether an indexed opcode falls through.
// Assumes: the byte is an opcode position byte (not a displacement/immediate).
module insn_opclass
    import insn_framer_pkg::*;
(
    input  page_e       page_i,
    input  logic [7:0]  byte_i,
    output logic        pfx_o,
    output page_e       pfx_page_o,
    output logic        disp_o,
    output logic [1:0]  imm_cnt_o,
    output logic        fall_o
);

    logic [1:0] fx;
    logic [2:0] fy;
    logic [2:0] fz;
    logic [1:0] fp;
    logic       fq;

    assign fx = byte_i[7:6];
    assign fy = byte_i[5:3];
    assign fz = byte_i[2:0];
    assign fp = byte_i[5:4];
    assign fq = byte_i[3];

    logic [1:0] main_imm;
    logic       uses_idx;
    logic       idx_disp;
    logic       is_pfx_byte;

    // Immediate byte count of a main-page opcode.
    always_comb begin
        main_imm = 2'd0;
        if (fx == 2'd0) begin
            if (fz == 3'd0 && fy >= 3'd2)            main_imm = 2'd1;
            else if (fz == 3'd1 && !fq)              main_imm = 2'd2;
            else if (fz == 3'd2 && byte_i[5])        main_imm = 2'd2;
            else if (fz == 3'd6)                     main_imm = 2'd1;
        end else if (fx == 2'd3) begin
            if (fz == 3'd2 || fz == 3'd4)            main_imm = 2'd2;
            else if (fz == 3'd3 && fy == 3'd0)       main_imm = 2'd2;
            else if (fz == 3'd3 && (fy == 3'd2 || fy == 3'd3)) main_imm = 2'd1;
            else if (fz == 3'd5 && fq && fp == 2'd0) main_imm = 2'd2;
            else if (fz == 3'd6)                     main_imm = 2'd1;
        end
    end

    // Whether an indexed-page opcode touches the index register at all.
    always_comb begin
        uses_idx = 1'b0;
        unique case (fx)
            2'd0: uses_idx = (fz == 3'd1 && fq) ||
                             (fp == 2'd2 && fz >= 3'd1 && fz <= 3'd6) ||
                             (byte_i == 8'h34) || (byte_i == 8'h35) || (byte_i == 8'h36);
            2'd1: uses_idx = (byte_i != 8'h76) &&
                             ((fz >= 3'd4 && fz <= 3'd6) || (fy >= 3'd4 && fy <= 3'd6));
            2'd2: uses_idx = (fz >= 3'd4 && fz <= 3'd6);
            2'd3: uses_idx = (byte_i == 8'hE1) || (byte_i == 8'hE3) || (byte_i == 8'hE5) ||
                             (byte_i == 8'hE9) || (byte_i == 8'hF9);
            default: uses_idx = 1'b0;
        endcase
    end

    // Whether an indexed-page opcode needs a displacement byte.
    always_comb begin
        idx_disp = (byte_i == 8'h34) || (byte_i == 8'h35) || (byte_i == 8'h36) ||
                   (fx == 2'd2 && fz == 3'd6) ||
                   (fx == 2'd1 && byte_i != 8'h76 && (fz == 3'd6 || fy == 3'd6));
    end

    assign is_pfx_byte = (byte_i == 8'hCB) || (byte_i == 8'hED) ||
                         (byte_i == 8'hDD) || (byte_i == 8'hFD);

    // Per-page selection of the classification outputs.
    always_comb begin
        pfx_o      = 1'b0;
        pfx_page_o = PG_MAIN;
        disp_o     = 1'b0;
        imm_cnt_o  = 2'd0;
        fall_o     = 1'b0;
        unique case (page_i)
            PG_MAIN, PG_IDX: begin
                pfx_o = is_pfx_byte;
                if (byte_i == 8'hCB)      pfx_page_o = (page_i == PG_IDX) ? PG_IDXBIT : PG_BIT;
                else if (byte_i == 8'hED) pfx_page_o = PG_EXT;
                else                      pfx_page_o = PG_IDX;
                imm_cnt_o = main_imm;
                if (page_i == PG_IDX) begin
                    disp_o = idx_disp;
                    fall_o = !uses_idx;
                end
            end
            PG_EXT: begin
                imm_cnt_o = (fx == 2'd1 && fz == 3'd3) ? 2'd2 : 2'd0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/insn_addr_track.sv
// Fetch address and instruction start tracker.
// Assumes: step is never high in the same cycle as restart (the sequencer
// stalls the byte port while a descriptor is held).
module insn_addr_track #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic          restart,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] start_o
);

    // Fetch address: load, or advance one per accepted byte with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_o <= '0;
        else if (load_en) addr_o <= load_addr;
        else if (step)    addr_o <= addr_o + AW'(1);
    end

    // Start address: load target, or the fetch address when a descriptor retires.
    always_ff @(posedge clk) begin
        if (!rst_n)       start_o <= '0;
        else if (load_en) start_o <= load_addr;
        else if (restart) start_o <= addr_o;
    end

    a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_en) |=> (addr_o == AW'($past(addr_o) + AW'(1))))
        else $error("a_r8_addr_step");

endmodule

// File: rtl/insn_framer.sv
// Opcode stream framer top: collects prefixes, opcode, displacement and
// immediates into one descriptor, held until acknowledged.
// Assumes: one byte per cycle at most; the consumer acknowledges with desc_ack.
module insn_framer
    import insn_framer_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [AW-1:0]    load_addr,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    input  logic             desc_ack,
    output logic             desc_valid,
    output logic             desc_done,
    output logic [AW-1:0]    desc_start,
    output logic [LEN_W-1:0] desc_len,
    output logic [2:0]       desc_page,
    output logic             desc_iy,
    output logic [7:0]       desc_op,
    output logic [1:0]       desc_x,
    output logic [2:0]       desc_y,
    output logic [2:0]       desc_z,
    output logic [1:0]       desc_p,
    output logic             desc_q,
    output logic [7:0]       desc_disp,
    output logic [15:0]      desc_imm,
    output logic             desc_fall
);

    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

    seq_state_e        state;
    page_e             page_q;
    logic              iy_q;
    logic [7:0]        op_q;
    logic [7:0]        disp_q;
    logic [15:0]       imm_q;
    logic [1:0]        imm_cnt_q;
    logic              fall_q;
    logic [LEN_W-1:0]  len_q;
    logic              done_q;
    logic              accept;
    logic              retire;

    logic              c_pfx;
    page_e             c_pfx_page;
    logic              c_disp;
    logic [1:0]        c_imm_cnt;
    logic              c_fall;
    logic [AW-1:0]     fetch_addr;

    assign in_ready = (state != ST_HOLD);
    assign accept   = in_valid && in_ready;
    assign retire   = (state == ST_HOLD) && desc_ack;

    insn_opclass u_class (
        .page_i     (page_q),
        .byte_i     (in_byte),
        .pfx_o      (c_pfx),
        .pfx_page_o (c_pfx_page),
        .disp_o     (c_disp),
        .imm_cnt_o  (c_imm_cnt),
        .fall_o     (c_fall)
    );

    insn_addr_track #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (load_addr),
        .step      (accept),
        .restart   (retire),
        .addr_o    (fetch_addr),
        .start_o   (desc_start)
    );

    // Sequencer: walks prefix, opcode, displacement and immediate bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || load_en || retire) begin
            state     <= ST_OP;
            page_q    <= PG_MAIN;
            iy_q      <= 1'b0;
            op_q      <= '0;
            disp_q    <= '0;
            imm_q     <= '0;
            imm_cnt_q <= '0;
            fall_q    <= 1'b0;
            len_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                len_q <= (len_q == LEN_MAX) ? len_q : len_q + 1'b1;
                unique case (state)
                    ST_OP: begin
                        if (page_q == PG_IDXBIT) begin
                            op_q   <= in_byte;
                            state  <= ST_HOLD;
                            done_q <= 1'b1;
                        end else if (c_pfx) begin
                            page_q <= c_pfx_page;
                            iy_q   <= (c_pfx_page == PG_IDX)    ? in_byte[5] :
                                      (c_pfx_page == PG_IDXBIT) ? iy_q : 1'b0;
                            if (c_pfx_page == PG_IDXBIT) state <= ST_DISP;
                        end else begin
                            op_q      <= in_byte;
                            fall_q    <= c_fall;
                            imm_cnt_q <= c_imm_cnt;
                            if (c_disp)                 state <= ST_DISP;
                            else if (c_imm_cnt != 2'd0) state <= ST_IMLO;
                            else begin
                                state  <= ST_HOLD;
                                done_q <= 1'b1;
                            end
                        end
                    end
                    ST_DISP: begin
                        disp_q <= in_byte;
                        if (page_q == PG_IDXBIT)         state <= ST_OP;
                        else if (imm_cnt_q != 2'd0)      state <= ST_IMLO;
                        else begin
                            state  <= ST_HOLD;
                            done_q <= 1'b1;
                        end
                    end
                    ST_IMLO: begin
                        imm_q[7:0] <= in_byte;
                        if (imm_cnt_q == 2'd2) state <= ST_IMHI;
                        else begin
                            state  <= ST_HOLD;
                            done_q <= 1'b1;
                        end
                    end
                    ST_IMHI: begin
                        imm_q[15:8] <= in_byte;
                        state       <= ST_HOLD;
                        done_q      <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign desc_valid = (state == ST_HOLD);
    assign desc_done  = done_q;
    assign desc_len   = len_q;
    assign desc_page  = page_q;
    assign desc_iy    = iy_q;
    assign desc_op    = op_q;
    assign desc_x     = op_q[7:6];
    assign desc_y     = op_q[5:3];
    assign desc_z     = op_q[2:0];
    assign desc_p     = op_q[5:4];
    assign desc_q     = op_q[3];
    assign desc_disp  = disp_q;
    assign desc_imm   = imm_q;
    assign desc_fall  = fall_q;

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ack && !load_en) |=>
            (desc_valid && $stable(desc_op) && $stable(desc_start) && $stable(desc_imm)))
        else $error("a_r9_hold_stable");

    a_r9_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |=> !desc_done)
        else $error("a_r9_done_once");

    a_r8_next_start: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ack && !load_en) |=>
            (desc_start == AW'($past(desc_start) + AW'($past(desc_len)))))
        else $error("a_r8_next_start");

    a_r3_idxbit_len: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_page == 3'd4) |-> (desc_len >= LEN_W'(4)))
        else $error("a_r3_idxbit_len");

endmodule

// File: tb/test_insn_framer.sv
`timescale 1ns/1ps
module test_insn_framer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_addr = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic        desc_ack = 1'b0;
    logic        desc_valid, desc_done, desc_iy, desc_q, desc_fall;
    logic [15:0] desc_start, desc_imm;
    logic [3:0]  desc_len;
    logic [2:0]  desc_page, desc_y, desc_z;
    logic [1:0]  desc_x, desc_p;
    logic [7:0]  desc_op, desc_disp;

    int n_run  = 0;
    int n_fail = 0;
    int exp_start = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    insn_framer i_insn_framer (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
        .desc_ack(desc_ack), .desc_valid(desc_valid), .desc_done(desc_done),
        .desc_start(desc_start), .desc_len(desc_len), .desc_page(desc_page),
        .desc_iy(desc_iy), .desc_op(desc_op), .desc_x(desc_x), .desc_y(desc_y),
        .desc_z(desc_z), .desc_p(desc_p), .desc_q(desc_q), .desc_disp(desc_disp),
        .desc_imm(desc_imm), .desc_fall(desc_fall)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic pulse_load(input logic [15:0] a);
        load_en = 1'b1; load_addr = a;
        @(posedge clk); #1;
        load_en = 1'b0;
        exp_start = a;
    endtask

    // Feed one instruction (byte 0 in seq[47:40]) and compare the descriptor
    // with the values expected from the requirements.
    task automatic run_insn(input logic [47:0] seq, input int n, input int e_page,
                            input int e_iy, input int e_op, input int e_disp,
                            input int e_imm, input int e_fall, input string rq);
        bit early = 0;
        bit stall = 0;
        logic [10:0] e_fields;
        for (int i = 0; i < n; i++) begin
            if (in_ready !== 1'b1) stall = 1;
            send_byte(seq[47-8*i -: 8]);
            if (i < n-1 && desc_valid) early = 1;
        end
        chk(!stall && !early, {rq, " R9"}, "early done or stall", {early, stall}, 0);
        chk(desc_valid && desc_done, {rq, " R9"}, "valid/done after last byte",
            {desc_valid, desc_done}, 2'b11);
        chk(desc_len == n, {rq, " R8"}, "length", desc_len, n);
        chk(desc_start == exp_start[15:0], {rq, " R8"}, "start", desc_start, exp_start);
        chk(desc_page == e_page && desc_iy == e_iy[0], {rq, " R2"}, "page/index",
            {desc_page, desc_iy}, {e_page[2:0], e_iy[0]});
        chk(desc_op == e_op[7:0], rq, "opcode", desc_op, e_op);
        // R1: field split computed arithmetically from the expected opcode
        e_fields = {2'((e_op / 64) % 4), 3'((e_op / 8) % 8), 3'(e_op % 8),
                    2'((e_op / 16) % 4), 1'((e_op / 8) % 2)};
        chk({desc_x, desc_y, desc_z, desc_p, desc_q} == e_fields, {rq, " R1"}, "fields",
            {desc_x, desc_y, desc_z, desc_p, desc_q}, e_fields);
        chk(desc_disp == e_disp[7:0], {rq, " R6"}, "displacement", desc_disp, e_disp);
        chk(desc_imm == e_imm[15:0], {rq, " R4"}, "immediate", desc_imm, e_imm);
        chk(desc_fall == e_fall[0], {rq, " R7"}, "fall-through", desc_fall, e_fall);
        @(posedge clk); #1;
        chk(desc_valid && !desc_done && !in_ready && desc_op == e_op[7:0], {rq, " R9"},
            "held state", {desc_valid, desc_done, in_ready}, 3'b100);
        desc_ack = 1'b1;
        @(posedge clk); #1;
        desc_ack = 1'b0;
        chk(!desc_valid && in_ready, {rq, " R9"}, "released", {desc_valid, in_ready}, 2'b01);
        exp_start = (exp_start + n) % 65536;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        chk(in_ready && !desc_valid && !desc_done && desc_start == 0, "R10", "reset state",
            {in_ready, desc_valid, desc_start}, {1'b1, 1'b0, 16'h0});

        // R4 main page operand counts
        run_insn(48'h00_00_00_00_00_00, 1, 0, 0, 'h00, 0, 0,      0, "R4 no-op");
        run_insn(48'h10_05_00_00_00_00, 2, 0, 0, 'h10, 0, 'h0005, 0, "R4 rel branch");
        run_insn(48'h08_00_00_00_00_00, 1, 0, 0, 'h08, 0, 0,      0, "R4 y1 no operand");
        run_insn(48'h01_34_12_00_00_00, 3, 0, 0, 'h01, 0, 'h1234, 0, "R4 word load");
        run_insn(48'h22_CD_AB_00_00_00, 3, 0, 0, 'h22, 0, 'hABCD, 0, "R4 z2 bit5");
        run_insn(48'h0A_00_00_00_00_00, 1, 0, 0, 'h0A, 0, 0,      0, "R4 z2 no bit5");
        run_insn(48'hDB_7F_00_00_00_00, 2, 0, 0, 'hDB, 0, 'h007F, 0, "R4 port byte");
        run_insn(48'hC3_00_80_00_00_00, 3, 0, 0, 'hC3, 0, 'h8000, 0, "R4 jump");
        run_insn(48'hCD_11_22_00_00_00, 3, 0, 0, 'hCD, 0, 'h2211, 0, "R4 call");
        run_insn(48'hC7_00_00_00_00_00, 1, 0, 0, 'hC7, 0, 0,      0, "R4 restart");
        // R2 bit page
        run_insn(48'hCB_47_00_00_00_00, 2, 1, 0, 'h47, 0, 0,      0, "R2 bit page");
        // R5 extended page
        run_insn(48'hED_4B_78_56_00_00, 4, 2, 0, 'h4B, 0, 'h5678, 0, "R5 ext word");
        run_insn(48'hED_B0_00_00_00_00, 2, 2, 0, 'hB0, 0, 0,      0, "R5 block op");
        run_insn(48'hED_06_00_00_00_00, 2, 2, 0, 'h06, 0, 0,      0, "R5 ext no-op");
        // R6 indexed displacement
        run_insn(48'hDD_34_FE_00_00_00, 3, 3, 0, 'h34, 'hFE, 0,   0, "R6 inc disp");
        run_insn(48'hFD_36_05_AA_00_00, 4, 3, 1, 'h36, 'h05, 'hAA, 0, "R6 disp+imm");
        run_insn(48'hDD_46_10_00_00_00, 3, 3, 0, 'h46, 'h10, 0,   0, "R6 x1 z6");
        run_insn(48'hDD_77_03_00_00_00, 3, 3, 0, 'h77, 'h03, 0,   0, "R6 x1 y6");
        run_insn(48'hDD_86_F0_00_00_00, 3, 3, 0, 'h86, 'hF0, 0,   0, "R6 x2 z6");
        run_insn(48'hFD_76_00_00_00_00, 2, 3, 1, 'h76, 0, 0,      1, "R6 halt exception");
        // R7 fall-through and index-using forms
        run_insn(48'hFD_21_34_12_00_00, 4, 3, 1, 'h21, 0, 'h1234, 0, "R7 index word");
        run_insn(48'hDD_01_CD_AB_00_00, 4, 3, 0, 'h01, 0, 'hABCD, 1, "R7 fall word");
        run_insn(48'hDD_44_00_00_00_00, 2, 3, 0, 'h44, 0, 0,      0, "R7 half reg");
        run_insn(48'hDD_C3_00_90_00_00, 4, 3, 0, 'hC3, 0, 'h9000, 1, "R7 fall jump");
        run_insn(48'hFD_E9_00_00_00_00, 2, 3, 1, 'hE9, 0, 0,      0, "R7 index jump");
        // R3 indexed-bit page
        run_insn(48'hDD_CB_05_C6_00_00, 4, 4, 0, 'hC6, 'h05, 0,   0, "R3 indexed bit");
        run_insn(48'hFD_CB_FF_0E_00_00, 4, 4, 1, 'h0E, 'hFF, 0,   0, "R3 indexed bit iy");
        // R2 chained prefixes
        run_insn(48'hDD_FD_09_00_00_00, 3, 3, 1, 'h09, 0, 0,      0, "R2 chain index");
        run_insn(48'hDD_ED_43_00_01_00, 5, 2, 0, 'h43, 0, 'h0100, 0, "R2 chain ext");

        // R8 wrap of the fetch address
        pulse_load(16'hFFFE);
        chk(desc_start == 16'hFFFE && in_ready, "R10", "load start", desc_start, 16'hFFFE);
        run_insn(48'h01_34_12_00_00_00, 3, 0, 0, 'h01, 0, 'h1234, 0, "R8 wrap");
        chk(exp_start == 1, "R8", "model wrap", exp_start, 1);
        run_insn(48'h00_00_00_00_00_00, 1, 0, 0, 'h00, 0, 0,      0, "R8 after wrap");

        // R10 load during a partial instruction
        send_byte(8'h01);
        pulse_load(16'h4000);
        run_insn(48'h00_00_00_00_00_00, 1, 0, 0, 'h00, 0, 0,      0, "R10 load mid");

        // R10 reset during a partial instruction
        send_byte(8'hDD);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        exp_start = 0;
        run_insn(48'h00_00_00_00_00_00, 1, 0, 0, 'h00, 0, 0,      0, "R10 reset mid");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule